// File: doc/BRIEF.md
# Path-Break Configurable Channel Buffer

This block is an elastic buffer for one valid/ready channel. Two elaboration-time parameters fix its shape. `MODE` says which handshake paths are cut by a register: none (0), data/valid only (1), ready only (2), or both (3). `SLOTS` is the total number of tokens the buffer can hold. The internal chain is built from three stage kinds and follows a fixed rule.

- A data/valid register stage holds one token. Its output valid and data come from a register, and its ready is combinational.
- A skid stage holds one token. It passes data and valid straight through and drives upstream ready from a register.
- A FIFO of zero-latency slots bypasses all three paths when empty.

The rule is as follows. Mode 0 uses `SLOTS` FIFO slots. Mode 1 puts a register stage in front of `SLOTS-1` FIFO slots. Mode 2 puts a skid stage in front of `SLOTS-1` FIFO slots. Mode 3 with more than one slot uses a register stage, then `SLOTS-2` FIFO slots, then a skid stage at the output. Mode 3 with a single slot uses a dedicated one-slot stage that registers data, valid and ready alike. A `SLOTS` value below one is rejected at elaboration.

Top module: `chan_buffer`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Tokens leave in the order they were accepted, with none lost or duplicated, under any backpressure pattern.
- R3: With `out_ready` held low, the buffer accepts exactly `SLOTS` tokens and never holds more than `SLOTS`.
- R4: In modes 1 and 3, `out_valid` is 0 in any cycle where the buffer holds no accepted token (one cycle of data/valid latency).
- R5: In modes 0 and 2, when the buffer is empty and `in_valid` is 1, `out_valid` is 1 in the same cycle and `out_data` equals `in_data`.
- R6: In modes 2 and 3, `in_ready` does not change when `out_ready` changes within a cycle.
- R7: In modes 0 and 1, `out_ready` high implies `in_ready` high in the same cycle.
- R8: Starting empty, with `in_valid` and `out_ready` held high for 20 cycles, the number of output transfers is 20 in modes 0 and 2. It is 19 in mode 1 and in mode 3 with more than one slot. It is 10 in mode 3 with one slot.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream token present |
| in_ready | output | 1 | Buffer can take a token |
| in_data | input | DATA_W | Upstream token payload |
| out_valid | output | 1 | Token offered downstream |
| out_ready | input | 1 | Downstream takes the token |
| out_data | output | DATA_W | Offered token payload |

## Verification
Two events can land in the same cycle: a new token being accepted and a stored one being released. This matters most when the buffer is full with combinational ready, or empty with a bypass path. Random backpressure with a high ready probability often meets a full buffer while `out_ready` is high. It also meets an empty buffer while `in_valid` is high. The outcome is judged from the ordered token sequence and from the occupancy the bench keeps. A one-cycle `out_ready` flip, done before the clock edge, shows whether `in_ready` follows it combinationally.

// File: rtl/chan_buffer_pkg.sv
// Shared types for the configurable channel buffer.
package chan_buffer_pkg;
    // Which handshake paths the composite cuts with a register.
    typedef enum logic [1:0] {
        BRK_NONE = 2'd0,
        BRK_DV   = 2'd1,
        BRK_RDY  = 2'd2,
        BRK_BOTH = 2'd3
    } brk_mode_e;
endpackage

// File: rtl/cb_dv_reg.sv
// One-slot stage that registers valid and data; ready is combinational.
// Assumes upstream holds valid and data stable until accepted.
module cb_dv_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Room exists when empty or when the held token leaves this cycle.
    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;

    // Occupancy flag follows the input whenever the stage can move.
    always_ff @(posedge clk) begin
        if (!rst_n)        full_q <= 1'b0;
        else if (in_ready) full_q <= in_valid;
    end

    // Payload captured on every accepted token.
    always_ff @(posedge clk) begin
        if (in_valid && in_ready) data_q <= in_data;
    end
endmodule

// File: rtl/cb_skid_reg.sv
// One-slot skid stage: data/valid pass through, upstream ready is a register.
// A token arriving while downstream stalls is parked and replayed later.
module cb_skid_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              park_q;
    logic [DATA_W-1:0] park_data_q;

    assign in_ready  = !park_q;
    assign out_valid = park_q || in_valid;
    assign out_data  = park_q ? park_data_q : in_data;

    // Park on a stalled pass-through, release when downstream takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            park_q <= 1'b0;
        end else if (park_q) begin
            if (out_ready) park_q <= 1'b0;
        end else if (in_valid && !out_ready) begin
            park_q <= 1'b1;
        end
    end

    // Payload of the parked token.
    always_ff @(posedge clk) begin
        if (!park_q && in_valid && !out_ready) park_data_q <= in_data;
    end
endmodule

// File: rtl/cb_seal_reg.sv
// One-slot stage cutting data, valid and ready: all outputs come from state.
// Accepts only when empty, so a stream moves one token every two cycles.
module cb_seal_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    assign in_ready  = !full_q;
    assign out_valid = full_q;
    assign out_data  = data_q;

    // Fill when empty, empty when taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                full_q <= 1'b0;
        else if (!full_q)          full_q <= in_valid;
        else if (out_ready)        full_q <= 1'b0;
    end

    // Payload loaded on acceptance.
    always_ff @(posedge clk) begin
        if (!full_q && in_valid) data_q <= in_data;
    end
endmodule

// File: rtl/cb_bypass_fifo.sv
// FIFO of DEPTH slots with zero latency on data, valid and ready.
// Empty: input flows straight to output. Full: accepts if a pop happens.
// Assumes DEPTH >= 1.
module cb_bypass_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wr_q, rd_q;
    logic [CW-1:0]     cnt_q;
    logic              empty, full, push, pop;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == FULL_CNT);
    assign in_ready  = !full || out_ready;
    assign out_valid = in_valid || !empty;
    assign out_data  = empty ? in_data : mem_q[rd_q];
    assign pop       = out_ready && !empty;
    assign push      = in_valid && in_ready && !(empty && out_ready);

    // Pointers and count advance on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= in_data;
    end
endmodule

// File: rtl/chan_buffer.sv
// Composite channel buffer. MODE picks which paths are registered and SLOTS
// the capacity; a fixed rule maps them to head stage, FIFO and tail stage.
// Assumes a standard valid/ready producer that holds data while stalled.
module chan_buffer
    import chan_buffer_pkg::*;
#(
    parameter int        DATA_W = 16,
    parameter int        SLOTS  = 2,
    parameter brk_mode_e MODE   = BRK_DV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    // Head kinds: 0 wire, 1 data/valid reg, 2 skid, 3 sealed one-slot.
    localparam int HEAD_KIND =
        (MODE == BRK_NONE) ? 0 :
        (MODE == BRK_DV)   ? 1 :
        (MODE == BRK_RDY)  ? 2 :
        (SLOTS == 1)       ? 3 : 1;
    localparam bit TAIL_SKID = (MODE == BRK_BOTH) && (SLOTS > 1);
    localparam int FIFO_N =
        (SLOTS < 1)          ? 0 :
        (MODE == BRK_NONE)   ? SLOTS :
        (MODE == BRK_BOTH)   ? ((SLOTS > 1) ? SLOTS - 2 : 0) :
                               SLOTS - 1;

    generate
        if (SLOTS < 1) begin : g_bad_slots
            $error("chan_buffer: SLOTS must be at least 1");
        end
    endgenerate

    logic              h_valid, h_ready, m_valid, m_ready;
    logic [DATA_W-1:0] h_data, m_data;

    // Head stage selection.
    generate
        if (HEAD_KIND == 1) begin : g_head_dv
            cb_dv_reg #(.DATA_W(DATA_W)) u_head (
                .clk(clk), .rst_n(rst_n),
                .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
                .out_valid(h_valid), .out_ready(h_ready), .out_data(h_data));
        end else if (HEAD_KIND == 2) begin : g_head_skid
            cb_skid_reg #(.DATA_W(DATA_W)) u_head (
                .clk(clk), .rst_n(rst_n),
                .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
                .out_valid(h_valid), .out_ready(h_ready), .out_data(h_data));
        end else if (HEAD_KIND == 3) begin : g_head_seal
            cb_seal_reg #(.DATA_W(DATA_W)) u_head (
                .clk(clk), .rst_n(rst_n),
                .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
                .out_valid(h_valid), .out_ready(h_ready), .out_data(h_data));
        end else begin : g_head_wire
            assign h_valid  = in_valid;
            assign h_data   = in_data;
            assign in_ready = h_ready;
        end
    endgenerate

    // Middle run of zero-latency FIFO slots.
    generate
        if (FIFO_N > 0) begin : g_mid_fifo
            cb_bypass_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_N)) u_mid (
                .clk(clk), .rst_n(rst_n),
                .in_valid(h_valid), .in_ready(h_ready), .in_data(h_data),
                .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data));
        end else begin : g_mid_wire
            assign m_valid = h_valid;
            assign m_data  = h_data;
            assign h_ready = m_ready;
        end
    endgenerate

    // Tail stage: skid only when both paths are cut over several slots.
    generate
        if (TAIL_SKID) begin : g_tail_skid
            cb_skid_reg #(.DATA_W(DATA_W)) u_tail (
                .clk(clk), .rst_n(rst_n),
                .in_valid(m_valid), .in_ready(m_ready), .in_data(m_data),
                .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
        end else begin : g_tail_wire
            assign out_valid = m_valid;
            assign out_data  = m_data;
            assign m_ready   = out_ready;
        end
    endgenerate
endmodule

// File: rtl/chan_buffer_chk.sv
// Port-level checker for chan_buffer; keeps its own occupancy count.
module chan_buffer_chk
    import chan_buffer_pkg::*;
#(
    parameter int        DATA_W = 16,
    parameter int        SLOTS  = 2,
    parameter brk_mode_e MODE   = BRK_DV
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    localparam int OW = $clog2(SLOTS + 2);
    localparam logic [OW-1:0] CAP = OW'(SLOTS);
    localparam bit DV_CUT  = (MODE == BRK_DV)   || (MODE == BRK_BOTH);
    localparam bit RDY_CUT = (MODE == BRK_RDY)  || (MODE == BRK_BOTH);

    logic [OW-1:0] occ_q;
    logic          acc, rel;
    assign acc = in_valid && in_ready;
    assign rel = out_valid && out_ready;

    // Tokens inside the buffer as seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)            occ_q <= '0;
        else if (acc && !rel)  occ_q <= occ_q + 1'b1;
        else if (rel && !acc)  occ_q <= occ_q - 1'b1;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CAP); // R3
    AST_DV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        DV_CUT && occ_q == '0 |-> !out_valid); // R4
    AST_DV_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !DV_CUT && occ_q == '0 && in_valid |-> out_valid); // R5
    AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !RDY_CUT && out_ready |-> in_ready); // R7
endmodule

bind chan_buffer chan_buffer_chk #(.DATA_W(DATA_W), .SLOTS(SLOTS), .MODE(MODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

// File: tb/tb_chan_buffer.sv
// Bench: six buffer configurations side by side, each with its own driver
// and in-order scoreboard, run through random and directed phases.
module tb_chan_buffer;
    import chan_buffer_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 6;
    localparam int LMODE  [NL] = '{0, 1, 1, 2, 3, 3};
    localparam int LSLOTS [NL] = '{3, 1, 3, 2, 1, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   phase = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   finished = 1'b0;
    logic [NL-1:0] lane_done = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] tok(int k);
        return 16'(k * 40503) ^ 16'(k >>> 3);
    endfunction

    function automatic int exp_rate(int mode, int slots);
        if (mode == 0 || mode == 2) return 20;
        if (mode == 3 && slots == 1) return 10;
        return 19;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic iv, ir, ov, orr;
        logic [15:0] id, od;

        chan_buffer #(.DATA_W(16), .SLOTS(LSLOTS[g]),
                      .MODE(brk_mode_e'(LMODE[g]))) dut (
            .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_ready(ir),
            .in_data(id), .out_valid(ov), .out_ready(orr), .out_data(od));

        initial begin
            int in_cnt = 0, out_cnt = 0, fill_acc = 0, rate_out = 0;
            int prev_phase = 0;
            bit pend = 0, stall = 0, final_done = 0;
            logic [15:0] stall_data = '0;
            iv = 0; orr = 0; id = '0;
            repeat (3) @(negedge clk);
            check(ov == 1'b0, "R1", "out_valid in reset", int'(ov), 0);
            check(ir == 1'b1, "R1", "in_ready in reset", int'(ir), 1);
            forever begin
                @(negedge clk);
                if (!rst_n) continue;
                if (phase != prev_phase) begin
                    if (prev_phase == 3)
                        check(fill_acc == LSLOTS[g], "R3", "tokens taken while stalled",
                              fill_acc, LSLOTS[g]);
                    if (prev_phase == 5)
                        check(rate_out == exp_rate(LMODE[g], LSLOTS[g]), "R8",
                              "transfers in 20 cycles", rate_out,
                              exp_rate(LMODE[g], LSLOTS[g]));
                    fill_acc = 0; rate_out = 0; prev_phase = phase;
                end
                case (phase)
                    1: begin iv = pend || ($urandom % 3 != 0); orr = ($urandom % 100 < 65); end
                    3: begin iv = 1; orr = 0; end
                    5: begin iv = 1; orr = 1; end
                    default: begin iv = pend; orr = 1; end
                endcase
                id = tok(in_cnt);
                #1;
                // R1 after reset: nothing stored, so the checks below start clean.
                if (stall) begin
                    check(ov == 1'b1, "R9", "valid held while stalled", int'(ov), 1);
                    check(od == stall_data, "R9", "data held while stalled",
                          int'(od), int'(stall_data));
                end
                if (LMODE[g] == 2 || LMODE[g] == 3) begin
                    logic r0;
                    r0 = ir; orr = !orr; #1;
                    check(ir == r0, "R6", "in_ready moved with out_ready", int'(ir), int'(r0));
                    orr = !orr; #1;
                end
                if (LMODE[g] == 0 || LMODE[g] == 1) begin
                    if (orr) check(ir == 1'b1, "R7", "in_ready with out_ready high", int'(ir), 1);
                end
                if (in_cnt == out_cnt) begin
                    if (LMODE[g] == 1 || LMODE[g] == 3)
                        check(ov == 1'b0, "R4", "valid while empty", int'(ov), 0);
                    else if (iv) begin
                        check(ov == 1'b1, "R5", "bypass valid", int'(ov), 1);
                        check(od == id, "R5", "bypass data", int'(od), int'(id));
                    end
                end
                if (ov && orr) begin
                    check(od == tok(out_cnt), "R2", "token order", int'(od), int'(tok(out_cnt)));
                    out_cnt++;
                    if (phase == 5) rate_out++;
                end
                if (iv && ir) begin
                    in_cnt++;
                    if (phase == 3) fill_acc++;
                end
                if (in_cnt - out_cnt > LSLOTS[g])
                    check(0, "R3", "occupancy above capacity", in_cnt - out_cnt, LSLOTS[g]);
                pend = iv && !ir;
                stall = ov && !orr;
                stall_data = od;
                if (phase == 7 && !final_done) begin
                    final_done = 1;
                    check(in_cnt == out_cnt, "R2", "tokens in versus out", out_cnt, in_cnt);
                    lane_done[g] = 1'b1;
                end
            end
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        phase = 1; repeat (3000) @(posedge clk);
        phase = 2; repeat (30)   @(posedge clk);
        phase = 3; repeat (8)    @(posedge clk);
        phase = 4; repeat (30)   @(posedge clk);
        phase = 5; repeat (20)   @(posedge clk);
        phase = 6; repeat (30)   @(posedge clk);
        phase = 7;
        wait (&lane_done);
        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule